// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block is the host side of a link to a serial EEPROM that stores 256 words of 16 bits each. A client issues one request at a time over a valid/ready handshake: read a word, write a word, unlock writes or lock writes. The block turns each request into a framed serial transfer on a chip select, a serial clock and a data line to the memory. For reads it shifts the returned word in from the memory's data output. For writes it then waits for the memory's ready/busy line to drop and release before it answers.

The serial clock phase length, the minimum deselect time and the busy timeout are all parameters counted in system clocks. Each answer goes back over a second valid/ready handshake with the read word and an error flag. The error flag is set when a write's busy pulse does not complete inside the timeout. A write sent while the memory is locked never shows busy, so it also ends with the error flag.

Top module: `seeprom_host`

## Requirements
- R1: Every frame starts with the bits 1010, followed by a 4-bit opcode, all sent most significant bit first and sampled by the memory on rising serial clock edges. The request codes on `req_op` are 0 read, 1 write, 2 unlock and 3 lock, and they map to the opcodes 1000, 0100, 0011 and 0000.
- R2: Read and write frames are 32 clocks long and carry the 8-bit address after the opcode. A write frame then carries 16 data bits, while a read frame clocks 16 filler bits during data return. Unlock and lock frames are 16 clocks long with an all-zero address field.
- R3: The serial clock stays low while `ee_cs_n` is high. `ee_cs_n` stays high for at least `CS_HIGH_CYC` system clocks between frames, including the first frame after reset.
- R4: `ee_mosi` does not change while the serial clock is high. It moves only at falling edges, so each bit is steady for a full low phase before its rising edge.
- R5: Every serial clock low phase and high phase lasts exactly `HALF_CYC` system clocks. This includes the first low phase after select falls.
- R6: A read samples `ee_miso` at rising edges 17 to 32 and assembles the word with the first sampled bit as bit 15. The word is returned on `rsp_rdata` with `rsp_err` low.
- R7: `ee_miso` is ignored outside the data phase of a read. Write, unlock and lock responses return `rsp_rdata` = 0 whatever `ee_miso` does.
- R8: After a write frame, the response is given only once `ee_rdy` has been seen low and then high again, and it carries `rsp_err` low.
- R9: A write whose busy pulse does not complete within `BUSY_TIMEOUT` system clocks after the frame ends is answered with `rsp_err` high. This covers both a busy line that never drops and one that never releases.
- R10: `req_ready` is high only when the block is idle. It drops at acceptance and stays low until after the response handshake and the deselect gap.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Request kind: 0 read, 1 write, 2 unlock, 3 lock |
| req_addr | input | 8 | Word address for read and write |
| req_wdata | input | 16 | Word to store on a write |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Client takes the response |
| rsp_rdata | output | 16 | Word read back (zero for other requests) |
| rsp_err | output | 1 | Busy handshake timed out |
| ee_cs_n | output | 1 | Active-low memory select |
| ee_sclk | output | 1 | Serial clock to the memory |
| ee_mosi | output | 1 | Serial data to the memory |
| ee_miso | input | 1 | Serial data from the memory |
| ee_rdy | input | 1 | Memory ready (high) or busy (low) |

## Verification
The bench models the memory itself, and it times every serial clock phase and deselect gap against the parameters. A controller that shortened the first low phase or dropped select too early would fail the phase and gap checks. A data line that moved during a high phase would corrupt the frames the model decodes. The bench toggles `ee_miso` outside read data phases, so a design that sampled the line there would return non-zero words for writes and for unlock or lock. It also exercises the busy line in three ways: a write while locked, where busy never appears; a stuck busy; and a normal pulse. A design that answered on the busy edge alone, or that answered before release, would either report a false success or answer ahead of the release cycle the model records.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 16;
  localparam int CMD_W   = 16;
  localparam int FRAME_W = CMD_W + WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [3:0] START_PAT = 4'b1010;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    ST_GAP, ST_IDLE, ST_SHIFT, ST_BUSY, ST_RESP
  } ctl_state_e;

  function automatic logic [3:0] op_code(req_op_e op);
    case (op)
      OP_READ:  return 4'b1000;
      OP_WRITE: return 4'b0100;
      OP_WREN:  return 4'b0011;
      default:  return 4'b0000;
    endcase
  endfunction

  // Frame is left-aligned: short command frames use only the upper CMD_W bits.
  function automatic logic [FRAME_W-1:0] build_frame(req_op_e op,
                                                     logic [ADDR_W-1:0] addr,
                                                     logic [WORD_W-1:0] data);
    logic [ADDR_W-1:0] a_fld;
    logic [WORD_W-1:0] d_fld;
    a_fld = (op == OP_READ || op == OP_WRITE) ? addr : '0;
    d_fld = (op == OP_WRITE) ? data : '0;
    return {START_PAT, op_code(op), a_fld, d_fld};
  endfunction

  function automatic logic [CNT_W-1:0] frame_clocks(req_op_e op);
    return (op == OP_READ || op == OP_WRITE) ? CNT_W'(FRAME_W) : CNT_W'(CMD_W);
  endfunction
endpackage

// File: rtl/seeprom_phase_timer.sv
module seeprom_phase_timer #(
  parameter int HALF_CYC = 40
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;
  logic          hi;
  logic          last;

  assign last      = (cnt == CW'(HALF_CYC - 1));
  assign rise_tick = run && last && !hi;
  assign fall_tick = run && last && hi;
  assign sclk      = hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seeprom_frame_shift.sv
module seeprom_frame_shift
  import seeprom_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nclk_in,
  input  logic               rd_in,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               miso,
  output logic               mosi,
  output logic               last_fall,
  output logic [WORD_W-1:0]  rdata
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   nclk;
  logic               rd_q;
  logic               rx_window;

  assign mosi      = sh[FRAME_W-1];
  assign last_fall = fall_tick && (idx == nclk - 1'b1);
  assign rx_window = rd_q && (idx >= CNT_W'(CMD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      idx   <= '0;
      nclk  <= '0;
      rd_q  <= 1'b0;
      rdata <= '0;
    end else if (load) begin
      sh    <= frame_in;
      idx   <= '0;
      nclk  <= nclk_in;
      rd_q  <= rd_in;
      rdata <= '0;
    end else begin
      if (rise_tick && rx_window)
        rdata <= {rdata[WORD_W-2:0], miso};
      if (fall_tick) begin
        sh  <= {sh[FRAME_W-2:0], 1'b0};
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seeprom_busy_watch.sv
module seeprom_busy_watch #(
  parameter int BUSY_TIMEOUT = 1000000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy_in,
  output logic done,
  output logic timeout
);
  localparam int TW = $clog2(BUSY_TIMEOUT + 1);

  logic [1:0]    sync;
  logic          rdy_s;
  logic          active;
  logic          seen_low;
  logic [TW-1:0] cnt;

  assign rdy_s   = sync[1];
  assign done    = active && seen_low && rdy_s;
  assign timeout = active && !done && (cnt == TW'(BUSY_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      active   <= 1'b0;
      seen_low <= 1'b0;
      cnt      <= '0;
    end else begin
      sync <= {sync[0], rdy_in};
      if (start) begin
        active   <= 1'b1;
        seen_low <= 1'b0;
        cnt      <= '0;
      end else if (active) begin
        if (done || timeout) active <= 1'b0;
        if (!rdy_s) seen_low <= 1'b1;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seeprom_host.sv
module seeprom_host
  import seeprom_pkg::*;
#(
  parameter int HALF_CYC     = 40,
  parameter int CS_HIGH_CYC  = 25,
  parameter int BUSY_TIMEOUT = 1000000
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs_n,
  output logic              ee_sclk,
  output logic              ee_mosi,
  input  logic              ee_miso,
  input  logic              ee_rdy
);
  localparam int GAP_W = $clog2(CS_HIGH_CYC + 1);

  ctl_state_e       state;
  logic [GAP_W-1:0] gap_cnt;
  logic             cs_n_q;
  logic             op_is_wr;
  logic             err_q;
  req_op_e          op_in;

  // Named internal events, also observed by the bound checker.
  logic accept, shifting, frame_last, busy_start, busy_done, busy_timeout;
  logic rise_tick, fall_tick;

  assign op_in      = req_op_e'(req_op);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign shifting   = (state == ST_SHIFT);
  assign busy_start = frame_last && op_is_wr;
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_err    = err_q;
  assign ee_cs_n    = cs_n_q;

  seeprom_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(shifting),
    .sclk(ee_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  seeprom_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .frame_in(build_frame(op_in, req_addr, req_wdata)),
    .nclk_in(frame_clocks(op_in)), .rd_in(op_in == OP_READ),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .miso(ee_miso),
    .mosi(ee_mosi), .last_fall(frame_last), .rdata(rsp_rdata)
  );

  seeprom_busy_watch #(.BUSY_TIMEOUT(BUSY_TIMEOUT)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .rdy_in(ee_rdy),
    .done(busy_done), .timeout(busy_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_GAP;
      gap_cnt  <= '0;
      cs_n_q   <= 1'b1;
      op_is_wr <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_GAP: begin
          if (gap_cnt == GAP_W'(CS_HIGH_CYC - 1)) begin
            gap_cnt <= '0;
            state   <= ST_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SHIFT;
            cs_n_q   <= 1'b0;
            op_is_wr <= (op_in == OP_WRITE);
            err_q    <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (frame_last) begin
            cs_n_q <= 1'b1;
            state  <= op_is_wr ? ST_BUSY : ST_RESP;
          end
        end
        ST_BUSY: begin
          if (busy_done) begin
            state <= ST_RESP;
          end else if (busy_timeout) begin
            state <= ST_RESP;
            err_q <= 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_GAP;
        end
        default: state <= ST_GAP;
      endcase
    end
  end
endmodule

// File: rtl/seeprom_host_chk.sv
module seeprom_host_chk #(
  parameter int HALF_CYC    = 40,
  parameter int CS_HIGH_CYC = 25
)(
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        rsp_err,
  input logic        busy_start
);
  int   cs_hi_run;
  int   ph_run;
  logic sclk_d;
  logic mosi_d;
  logic tog;

  assign tog = (sclk != sclk_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_run <= 0;
      ph_run    <= 0;
      sclk_d    <= 1'b0;
      mosi_d    <= 1'b0;
    end else begin
      sclk_d    <= sclk;
      mosi_d    <= mosi;
      cs_hi_run <= cs_n ? ((cs_hi_run < CS_HIGH_CYC) ? cs_hi_run + 1 : cs_hi_run) : 0;
      ph_run    <= tog ? 1 : ((ph_run < HALF_CYC) ? ph_run + 1 : ph_run);
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> cs_hi_run >= CS_HIGH_CYC); // R3
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && sclk_d) |-> (mosi == mosi_d)); // R4
  AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    tog |-> ph_run >= HALF_CYC); // R5
  AST_WRITE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |=> !rsp_valid); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && cs_n)); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R11
endmodule

bind seeprom_host seeprom_host_chk #(.HALF_CYC(HALF_CYC), .CS_HIGH_CYC(CS_HIGH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(ee_cs_n), .sclk(ee_sclk), .mosi(ee_mosi),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy_start(busy_start)
);

// File: tb/seeprom_host_bench.sv
module seeprom_host_bench;
  localparam int HALF = 3;
  localparam int CSH  = 4;
  localparam int TMO  = 400;
  localparam int BLEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        cs_n, sclk, mosi;
  logic        miso = 1'b1;
  logic        rdy = 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  int busy_mode = 0;
  int cur_op = 0;
  logic [7:0]  cur_addr = 8'd0;
  logic [15:0] cur_data = 16'd0;
  int release_cyc = -1;

  seeprom_host #(.HALF_CYC(HALF), .CS_HIGH_CYC(CSH), .BUSY_TIMEOUT(TMO)) u_seeprom_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs_n(cs_n), .ee_sclk(sclk), .ee_mosi(mosi), .ee_miso(miso), .ee_rdy(rdy)
  );

  function automatic logic [15:0] init_word(input logic [7:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  function automatic logic [3:0] want_opc(input int op);
    if (op == 0) return 4'b1000;
    if (op == 1) return 4'b0100;
    if (op == 2) return 4'b0011;
    return 4'b0000;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Memory device model and per-cycle protocol monitor.
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
  int run = 0, gap = 0, nrise = 0, bstate = 0, bcnt = 0;
  logic [31:0] rxv = 32'd0;
  logic [15:0] rword = 16'd0;
  logic rd_act = 1'b0, dev_en = 1'b0, dev_init = 1'b0;
  logic [15:0] dev_mem [256];
  logic [7:0]  b_addr = 8'd0;
  logic [15:0] b_data = 16'd0;

  always @(negedge clk) begin
    logic [3:0] hdr, opc;
    logic [7:0] ad;
    logic [15:0] dt;
    cyc++;
    if (!dev_init) begin
      for (int i = 0; i < 256; i++) dev_mem[i] = init_word(8'(i));
      dev_init = 1'b1;
    end
    if (cs_n === 1'b1 && sclk === 1'b1) chk("R3 clock parked while deselected", sclk, 0);
    if (sclk && p_sclk && mosi !== p_mosi) chk("R4 data steady in high phase", mosi, p_mosi);
    if (sclk !== p_sclk) begin
      if (!p_cs) chk("R5 phase length", run, HALF);
      run = 1;
    end else run++;
    if (cs_n === 1'b0 && p_cs) begin
      chk("R3 deselect gap", gap >= CSH, 1);
      gap = 0; run = 1; nrise = 0; rxv = 0; rd_act = 1'b0;
    end
    if (cs_n === 1'b1) gap++;
    if (!cs_n && sclk && !p_sclk) begin
      rxv = {rxv[30:0], mosi};
      nrise++;
    end
    if (!cs_n && !sclk && p_sclk) begin
      if (nrise == 16 && rxv[15:8] == 8'hA8) begin
        rd_act = 1'b1;
        rword = dev_mem[rxv[7:0]];
      end
      if (rd_act && nrise >= 16 && nrise < 32) miso = rword[31 - nrise];
      else miso = ~miso;
    end
    if (cs_n && !p_cs) begin
      if (nrise == 32) begin
        hdr = rxv[31:28]; opc = rxv[27:24]; ad = rxv[23:16]; dt = rxv[15:0];
      end else begin
        hdr = rxv[15:12]; opc = rxv[11:8]; ad = rxv[7:0]; dt = 16'd0;
      end
      chk("R1 start pattern", hdr, 4'b1010);
      chk("R1 opcode", opc, want_opc(cur_op));
      chk("R2 clock count", nrise, (cur_op <= 1) ? 32 : 16);
      chk("R2 address field", ad, (cur_op <= 1) ? cur_addr : 8'd0);
      if (cur_op == 1) chk("R2 data field", dt, cur_data);
      if (opc == 4'b0011) dev_en = 1'b1;
      if (opc == 4'b0000) dev_en = 1'b0;
      if (opc == 4'b0100 && nrise == 32 && dev_en) begin
        b_addr = ad; b_data = dt; bstate = 1; bcnt = 3;
      end
      rd_act = 1'b0;
      miso = 1'b1;
    end
    case (bstate)
      1: begin
        bcnt--;
        if (bcnt == 0) begin
          rdy = 1'b0; bcnt = BLEN;
          bstate = (busy_mode != 0) ? 3 : 2;
        end
      end
      2: begin
        bcnt--;
        if (bcnt == 0) begin
          rdy = 1'b1; dev_mem[b_addr] = b_data; release_cyc = cyc; bstate = 0;
        end
      end
      3: if (busy_mode == 0) begin rdy = 1'b1; bstate = 0; end
      default: ;
    endcase
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  logic [15:0] exp_mem [256];

  task automatic xact(input int op, input logic [7:0] a, input logic [15:0] d,
                      input logic [15:0] exp_d, input logic exp_e, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_op = op; cur_addr = a; cur_data = d;
    if (op == 1) release_cyc = -1;
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " / R10 ready low after accept"}, req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    if (op == 1 && !exp_e)
      chk("R8 answer after busy release", (release_cyc >= 0 && cyc > release_cyc), 1);
    repeat (3) @(negedge clk);
    chk({tag, " / R11 response held"}, rsp_valid, 1);
    chk({tag, " data"}, rsp_rdata, exp_d);
    chk({tag, " error flag"}, rsp_err, exp_e);
    chk("R10 ready low while responding", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 response retired", rsp_valid, 0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_word(8'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset select high", cs_n, 1);
    chk("R3 reset clock low", sclk, 0);
    chk("R10 reset no response", rsp_valid, 0);
    chk("R10 reset gap holds ready low", req_ready, 0);
    repeat (10) @(negedge clk);
    chk("R10 idle ready", req_ready, 1);

    xact(0, 8'h12, 16'h0, exp_mem[8'h12], 1'b0, "R6 read 12");
    xact(0, 8'h00, 16'h0, exp_mem[8'h00], 1'b0, "R6 read 00");
    xact(0, 8'hFF, 16'h0, exp_mem[8'hFF], 1'b0, "R6 read FF");
    xact(1, 8'h12, 16'hBEEF, 16'h0, 1'b1, "R9 write while locked");
    xact(0, 8'h12, 16'h0, exp_mem[8'h12], 1'b0, "R9 locked write left word");
    xact(2, 8'h77, 16'hFFFF, 16'h0, 1'b0, "R7 unlock");
    xact(1, 8'h12, 16'hBEEF, 16'h0, 1'b0, "R8 write 12");
    exp_mem[8'h12] = 16'hBEEF;
    xact(0, 8'h12, 16'h0, exp_mem[8'h12], 1'b0, "R6 read back 12");
    xact(1, 8'hFF, 16'h8001, 16'h0, 1'b0, "R8 write FF");
    exp_mem[8'hFF] = 16'h8001;
    xact(0, 8'hFF, 16'h0, exp_mem[8'hFF], 1'b0, "R6 read back FF");
    xact(0, 8'h80, 16'h0, exp_mem[8'h80], 1'b0, "R6 read 80");
    busy_mode = 1;
    xact(1, 8'h40, 16'h1234, 16'h0, 1'b1, "R9 stuck busy");
    busy_mode = 0;
    repeat (10) @(negedge clk);
    xact(0, 8'h40, 16'h0, exp_mem[8'h40], 1'b0, "R6 read 40 after abort");
    xact(3, 8'h55, 16'h0, 16'h0, 1'b0, "R7 lock");
    xact(1, 8'h05, 16'hAAAA, 16'h0, 1'b1, "R9 write after lock");
    xact(0, 8'h05, 16'h0, exp_mem[8'h05], 1'b0, "R6 read 05");
    finish_run();
  end
endmodule